// File: doc/BRIEF.md
# USB Host Frame Timing Counter

This block keeps frame time for a USB host controller. A 14-bit down-counter tracks how many bit times remain in the current frame. When it has reached zero, the next bit-time tick reloads it from a programmable interval. Each reload also advances a 16-bit frame number and emits a one-cycle start-of-frame pulse. A toggle bit is copied from the interval configuration at every reload. Software writes a new interval with the opposite toggle and can then see from the remaining register when the new interval has taken effect.

The counter runs only while the controller is in the operational state. On a rising edge of that state input it loads the interval at once, so the first frame has full length. Two 32-bit registers are reached through a small select/write/read port, one for the remaining count and one for the frame number. The frame number is 16 bits so that software can extend it to 32 bits by watching for wraps.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining count, the remaining toggle, the frame number and the start-of-frame pulse are all zero.
- R2: While operational and not on the entry cycle, each `bit_tick` with a non-zero remaining count lowers the count by one in the next cycle.
- R3: A `bit_tick` while operational with the remaining count at zero reloads the count from `ivl_value` and copies `ivl_toggle` into the remaining toggle.
- R4: On every reload by R3 the frame number rises by one, wrapping from 0xFFFF to 0x0000. `sof_pulse` is high for exactly the one cycle in which the reloaded values first appear.
- R5: In the cycle where `oper_active` rises, the count loads `ivl_value`, any `bit_tick` is ignored, and the frame number, toggle and `sof_pulse` do not change.
- R6: While `oper_active` is low, ticks are ignored: count and frame number hold and `sof_pulse` stays low.
- R7: `ivl_value` is sampled only at the reload or entry moment, so a change in the middle of a frame does not alter the frame already running.
- R8: `reg_rdata` is combinational. With `reg_sel`=0 it returns the count in bits 13:0 and the toggle in bit 31. With `reg_sel`=1 it returns the frame number in bits 15:0. All other bits read zero.
- R9: When `reg_wr` is high, `reg_sel`=0 loads the count from bits 13:0 and the toggle from bit 31, and `reg_sel`=1 loads the frame number from bits 15:0. Written reserved bits have no effect.
- R10: A register write in the same cycle as a reload tick wins for the register it targets. The other register still takes its tick update, and `sof_pulse` still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| ivl_value | input | 14 | Frame interval reload value |
| ivl_toggle | input | 1 | Interval toggle bit from configuration |
| oper_active | input | 1 | High while the controller is operational |
| reg_sel | input | 1 | 0 selects remaining register, 1 selects frame number register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| remain_cnt | output | 14 | Current remaining count |
| remain_toggle | output | 1 | Current remaining toggle |
| frame_num | output | 16 | Current frame number |
| sof_pulse | output | 1 | Start-of-frame pulse |

## Verification
A software register write can land on the same cycle as the tick that reloads an expired count. The bench sets the count to zero through the port and then raises `bit_tick` together with a write, once to the frame number register and once to the remaining register. In each case it expects the written register to hold the written value. The other register must show its tick result: either the reloaded interval or the incremented number. `sof_pulse` must be high in the following cycle.

// File: rtl/usb_frame_pkg.sv
package usb_frame_pkg;
    localparam int REM_W_DEF  = 14;
    localparam int FN_W_DEF   = 16;
    localparam int DATA_W_DEF = 32;

    typedef enum logic {
        SEL_REMAIN = 1'b0,
        SEL_NUMBER = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/frame_remain_ctr.sv
module frame_remain_ctr #(
    parameter int REM_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             oper,
    input  logic [REM_W-1:0] ivl,
    input  logic             ivl_tog,
    input  logic             wr_en,
    input  logic [REM_W-1:0] wr_cnt,
    input  logic             wr_tog,
    output logic [REM_W-1:0] cnt,
    output logic             tog,
    output logic             wrap
);
    typedef struct packed {
        logic [REM_W-1:0] cnt;
        logic             tog;
        logic             oper;
    } rem_state_t;

    rem_state_t st_d, st_q;
    logic       entry;
    logic       run_tick;

    always_comb begin
        st_d     = st_q;
        st_d.oper = oper;
        entry    = oper && !st_q.oper;
        run_tick = oper && st_q.oper && tick;
        wrap     = run_tick && (st_q.cnt == '0);
        if (entry) begin
            st_d.cnt = ivl;
        end else if (wrap) begin
            st_d.cnt = ivl;
            st_d.tog = ivl_tog;
        end else if (run_tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_en) begin
            st_d.cnt = wr_cnt;
            st_d.tog = wr_tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign tog = st_q.tog;
endmodule

// File: rtl/frame_num_ctr.sv
module frame_num_ctr #(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            wr_en,
    input  logic [FN_W-1:0] wr_val,
    output logic [FN_W-1:0] num,
    output logic            sof
);
    typedef struct packed {
        logic [FN_W-1:0] num;
        logic            sof;
    } num_state_t;

    num_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sof = inc;
        if (wr_en)    st_d.num = wr_val;
        else if (inc) st_d.num = st_q.num + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign num = st_q.num;
    assign sof = st_q.sof;
endmodule

// File: rtl/frame_reg_port.sv
module frame_reg_port
    import usb_frame_pkg::*;
#(
    parameter int REM_W  = 14,
    parameter int FN_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REM_W-1:0]  cnt,
    input  logic              tog,
    input  logic [FN_W-1:0]   num,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_rem,
    output logic              wr_num,
    output logic [REM_W-1:0]  wr_cnt,
    output logic              wr_tog,
    output logic [FN_W-1:0]   wr_num_val
);
    localparam int TOG_POS = DATA_W - 1;

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(sel) == SEL_REMAIN) begin
            rdata[REM_W-1:0] = cnt;
            rdata[TOG_POS]   = tog;
        end else begin
            rdata[FN_W-1:0]  = num;
        end
    end

    assign wr_rem     = wr && (reg_sel_e'(sel) == SEL_REMAIN);
    assign wr_num     = wr && (reg_sel_e'(sel) == SEL_NUMBER);
    assign wr_cnt     = wdata[REM_W-1:0];
    assign wr_tog     = wdata[TOG_POS];
    assign wr_num_val = wdata[FN_W-1:0];
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_frame_pkg::*;
#(
    parameter int REM_W  = REM_W_DEF,
    parameter int FN_W   = FN_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [REM_W-1:0]  ivl_value,
    input  logic              ivl_toggle,
    input  logic              oper_active,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [REM_W-1:0]  remain_cnt,
    output logic              remain_toggle,
    output logic [FN_W-1:0]   frame_num,
    output logic              sof_pulse
);
    logic             wr_rem, wr_num, wr_tog, wrap;
    logic [REM_W-1:0] wr_cnt;
    logic [FN_W-1:0]  wr_num_val;

    frame_reg_port #(.REM_W(REM_W), .FN_W(FN_W), .DATA_W(DATA_W)) u_port (
        .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
        .cnt(remain_cnt), .tog(remain_toggle), .num(frame_num),
        .rdata(reg_rdata), .wr_rem(wr_rem), .wr_num(wr_num),
        .wr_cnt(wr_cnt), .wr_tog(wr_tog), .wr_num_val(wr_num_val)
    );

    frame_remain_ctr #(.REM_W(REM_W)) u_remain (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .oper(oper_active),
        .ivl(ivl_value), .ivl_tog(ivl_toggle), .wr_en(wr_rem),
        .wr_cnt(wr_cnt), .wr_tog(wr_tog),
        .cnt(remain_cnt), .tog(remain_toggle), .wrap(wrap)
    );

    frame_num_ctr #(.FN_W(FN_W)) u_num (
        .clk(clk), .rst_n(rst_n), .inc(wrap), .wr_en(wr_num),
        .wr_val(wr_num_val), .num(frame_num), .sof(sof_pulse)
    );
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
    parameter int REM_W  = 14,
    parameter int FN_W   = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic [REM_W-1:0]  ivl_value,
    input logic              ivl_toggle,
    input logic              oper_active,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [REM_W-1:0]  remain_cnt,
    input logic              remain_toggle,
    input logic [FN_W-1:0]   frame_num,
    input logic              sof_pulse
);
    logic oper_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) oper_prev <= 1'b0;
        else        oper_prev <= oper_active;
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_active && oper_prev && bit_tick && !reg_wr && remain_cnt != '0)
        |=> remain_cnt == $past(remain_cnt) - 1'b1); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_active && oper_prev && bit_tick && !reg_wr && remain_cnt == '0)
        |=> (remain_cnt == $past(ivl_value)) && (remain_toggle == $past(ivl_toggle))); // R3
    AST_FRAME_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_active && oper_prev && bit_tick && !reg_wr && remain_cnt == '0)
        |=> (frame_num == $past(frame_num) + 1'b1) && sof_pulse); // R4
    AST_SOF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> $past(bit_tick) && $past(oper_active)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oper_active && !reg_wr) |=> $stable(remain_cnt) && $stable(frame_num)); // R6
    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_active && !oper_prev && !reg_wr)
        |=> remain_cnt == $past(ivl_value) && !sof_pulse); // R5
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel ? (reg_rdata[DATA_W-1:FN_W] == '0) : (reg_rdata[DATA_W-2:REM_W] == '0)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> frame_num == $past(reg_wdata[FN_W-1:0])); // R10
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.REM_W(REM_W), .FN_W(FN_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ivl_value(ivl_value),
    .ivl_toggle(ivl_toggle), .oper_active(oper_active), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .remain_cnt(remain_cnt), .remain_toggle(remain_toggle),
    .frame_num(frame_num), .sof_pulse(sof_pulse)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [13:0] ivl_value = '0;
    logic        ivl_toggle = 1'b0;
    logic        oper_active = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [13:0] remain_cnt;
    logic        remain_toggle;
    logic [15:0] frame_num;
    logic        sof_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_frame_timer u_usb_frame_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ivl_value(ivl_value),
        .ivl_toggle(ivl_toggle), .oper_active(oper_active), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .remain_cnt(remain_cnt), .remain_toggle(remain_toggle),
        .frame_num(frame_num), .sof_pulse(sof_pulse)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(logic tick);
        bit_tick = tick;
        @(negedge clk);
        bit_tick = 1'b0;
        reg_wr   = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "cnt", 32'(remain_cnt), 0);
        check("R1", "tog", 32'(remain_toggle), 0);
        check("R1", "num", 32'(frame_num), 0);
        check("R1", "sof", 32'(sof_pulse), 0);
        reg_sel = 1'b0; #1;
        check("R1", "rdata rem", reg_rdata, 0);
    endtask

    task automatic t_entry;
        ivl_value = 14'd5; ivl_toggle = 1'b1; oper_active = 1'b1;
        step(1'b1);
        check("R5", "entry cnt", 32'(remain_cnt), 5);
        check("R5", "entry tog", 32'(remain_toggle), 0);
        check("R5", "entry num", 32'(frame_num), 0);
        check("R5", "entry sof", 32'(sof_pulse), 0);
    endtask

    task automatic t_count_reload;
        for (int i = 4; i >= 0; i--) begin
            step(1'b1);
            check("R2", "dec cnt", 32'(remain_cnt), 32'(i));
            check("R2", "dec sof", 32'(sof_pulse), 0);
        end
        step(1'b0);
        check("R2", "no tick hold", 32'(remain_cnt), 0);
        step(1'b1);
        check("R3", "reload cnt", 32'(remain_cnt), 5);
        check("R3", "reload tog", 32'(remain_toggle), 1);
        check("R4", "num inc", 32'(frame_num), 1);
        check("R4", "sof high", 32'(sof_pulse), 1);
        step(1'b0);
        check("R4", "sof one cycle", 32'(sof_pulse), 0);
    endtask

    task automatic t_midframe;
        ivl_value = 14'd2; ivl_toggle = 1'b0;
        for (int i = 4; i >= 0; i--) begin
            step(1'b1);
            check("R7", "old frame cnt", 32'(remain_cnt), 32'(i));
        end
        step(1'b1);
        check("R7", "new ivl cnt", 32'(remain_cnt), 2);
        check("R3", "new tog", 32'(remain_toggle), 0);
        check("R4", "num 2", 32'(frame_num), 2);
    endtask

    task automatic t_idle;
        step(1'b1);
        oper_active = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1'b1);
            check("R6", "hold cnt", 32'(remain_cnt), 1);
            check("R6", "no sof", 32'(sof_pulse), 0);
        end
        check("R6", "hold num", 32'(frame_num), 2);
    endtask

    task automatic t_regs;
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        step(1'b0);
        check("R9", "wr cnt", 32'(remain_cnt), 32'h3FFF);
        check("R9", "wr tog", 32'(remain_toggle), 1);
        #1;
        check("R8", "rd rem", reg_rdata, 32'h8000_3FFF);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hABCD_1234;
        step(1'b0);
        reg_sel = 1'b1; #1;
        check("R8", "rd num", reg_rdata, 32'h0000_1234);
        check("R9", "num val", 32'(frame_num), 32'h1234);
        oper_active = 1'b1; ivl_value = 14'd9;
        step(1'b0);
        check("R5", "re-entry cnt", 32'(remain_cnt), 9);
    endtask

    task automatic t_wrap;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_FFFF;
        step(1'b0);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0;
        step(1'b0);
        ivl_value = 14'd3; ivl_toggle = 1'b1;
        step(1'b1);
        check("R4", "wrap num", 32'(frame_num), 0);
        check("R4", "wrap sof", 32'(sof_pulse), 1);
        check("R3", "wrap cnt", 32'(remain_cnt), 3);
    endtask

    task automatic t_collide;
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0;
        step(1'b0);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_0100;
        step(1'b1);
        check("R10", "num write wins", 32'(frame_num), 32'h0100);
        check("R10", "cnt reloaded", 32'(remain_cnt), 3);
        check("R10", "sof fires", 32'(sof_pulse), 1);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0;
        step(1'b0);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0000_0007;
        step(1'b1);
        check("R10", "cnt write wins", 32'(remain_cnt), 7);
        check("R10", "tog write wins", 32'(remain_toggle), 0);
        check("R10", "num ticked", 32'(frame_num), 32'h0101);
        check("R10", "sof fires 2", 32'(sof_pulse), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_entry();
        t_count_reload();
        t_midframe();
        t_idle();
        t_regs();
        t_wrap();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule